// File: doc/BRIEF.md
# SPI EEPROM Word Reader with Direct Pin Access

This block sits inside a network controller and owns the four pins of a serial SPI EEPROM. Two host registers are visible through a simple register port selected by one address line. A control register carries the pin bits for software bit-banging, a request/grant handshake, a presence flag and a device size code. A read register launches an automatic fetch of one 16-bit word and reports when the result is ready.

Two masters share the pins. Without a grant, an internal engine serves word fetches: it sends the read opcode and a byte address, shifts in two bytes and returns them as one word. With a grant, the pins follow the control register bits directly, so software can run any SPI sequence, for example page programming. Grant is given only to an idle engine, and fetches issued during a grant wait for its release. If the pins stay still for a programmable number of cycles while granted, the hardware withdraws the request and the grant.

Top module: `eeprom_port_ctrl`

## Requirements
- R1: After reset the control register (host_sel=0) reads clock bit 0 = 0, chip-select bit 1 = 1, data-out bit 2 = 0, request bit 6 = 0 and grant bit 7 = 0, and the pins show spi_cs_n = 1, spi_sck = 0.
- R2: Control bit 8 reads the PRESENT parameter and bits 14:11 read the size code (7 for a 16 kB device, 8 for a 32 kB device, taken from DEV_KB); host writes do not change either field.
- R3: Writing the read register (host_sel=1) with bit 0 set fetches the word whose address is in bits 15:2: the engine lowers spi_cs_n, sends opcode 0x03 and then the 16-bit byte address (word address times two), MSB first, in SPI mode 0.
- R4: A fetch start clears read-register bit 1; at the end of the fetch bit 1 sets and bits 31:16 hold the word, whose low byte is the byte at the even address and whose high byte is the byte at the next odd address. Bit 0 reads 1 while a fetch is outstanding.
- R5: Writing control bit 6 = 1 while the engine is idle and no fetch waits makes grant bit 7 read 1 on the very next register read.
- R6: While grant is held, spi_sck, spi_cs_n and spi_mosi follow control bits 0, 1 and 2; control bit 3 always reflects the spi_miso pin.
- R7: Without grant, writes to control bits 0 to 2 do not move the pins.
- R8: A fetch requested while grant is held does not start (spi_cs_n and read bit 1 unchanged) until request bit 6 is written to 0, and then completes.
- R9: A request made while a fetch is running is not granted until that fetch has finished.
- R10: While granted, if IDLE_TIMEOUT clock cycles pass with no host write that changes control bits 0 to 2, the request and grant both clear; such a change restarts the count.
- R11: Outside a grant and between fetches, spi_cs_n is high and spi_sck is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register select: 0 control, 1 read register |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected register |
| spi_sck | output | 1 | EEPROM serial clock |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The embedded properties watch on every cycle that grant never coexists with a running fetch, that grant implies a standing request and rises only from an idle engine, that a waiting fetch survives a grant, that the inactivity counter stays below its limit, that the clock never rises with chip select high, and that the pins idle high and low outside a grant. The opcode and address order on the wire, the byte order of the returned word, the exact cycle the grant appears and the cycle the timeout withdraws it, and the effect of a pin change on that timeout are shown only by the bench scenarios, against an EEPROM model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  // Control register bit positions
  localparam int unsigned CB_SCK  = 0;
  localparam int unsigned CB_CS   = 1;
  localparam int unsigned CB_DO   = 2;
  localparam int unsigned CB_DI   = 3;
  localparam int unsigned CB_REQ  = 6;
  localparam int unsigned CB_GNT  = 7;
  localparam int unsigned CB_PRES = 8;
  localparam int unsigned CB_SIZE = 11;
  localparam int unsigned SIZE_W  = 4;
  // Read register bit positions
  localparam int unsigned RB_GO   = 0;
  localparam int unsigned RB_DONE = 1;
  localparam int unsigned RB_ADDR = 2;
  localparam int unsigned RB_DATA = 16;
  localparam int unsigned WADDR_W = 14;
  localparam int unsigned WORD_W  = 16;
  // Serial frame
  localparam logic [7:0]  OP_READ    = 8'h03;
  localparam int unsigned CMD_BITS   = 24;
  localparam int unsigned FRAME_BITS = CMD_BITS + WORD_W;

  typedef enum logic {RD_IDLE = 1'b0, RD_XFER = 1'b1} rd_state_e;

  function automatic logic [SIZE_W-1:0] size_code(input int unsigned kb);
    return (kb >= 32) ? 4'd8 : 4'd7;
  endfunction
endpackage

// File: rtl/eep_rst_sync.sv
module eep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/eep_word_reader.sv
module eep_word_reader
  import eep_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  rd_state_e             state_q, state_d;
  logic                  sck_q, sck_d;
  logic                  csn_q, csn_d;
  logic                  done_q, done_d;
  logic [CMD_BITS-1:0]   tx_q, tx_d;
  logic [WORD_W-1:0]     rx_q, rx_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [DIV_W-1:0]      div_q, div_d;

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    csn_d   = csn_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    div_d   = div_q;
    done_d  = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (start_i) begin
          state_d = RD_XFER;
          csn_d   = 1'b0;
          sck_d   = 1'b0;
          tx_d    = {OP_READ, 1'b0, waddr_i, 1'b0};
          rx_d    = '0;
          bit_d   = '0;
          div_d   = '0;
        end
      end
      RD_XFER: begin
        if (div_q == DIV_W'(SCK_HALF - 1)) begin
          div_d = '0;
          if (!sck_q) begin
            sck_d = 1'b1;
            if (bit_q >= BIT_W'(CMD_BITS)) rx_d = {rx_q[WORD_W-2:0], miso_i};
          end else begin
            sck_d = 1'b0;
            if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
              state_d = RD_IDLE;
              csn_d   = 1'b1;
              done_d  = 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
              tx_d  = {tx_q[CMD_BITS-2:0], 1'b0};
            end
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      done_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      csn_q   <= csn_d;
      done_q  <= done_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      div_q   <= div_d;
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = csn_q;
  assign mosi_o = (state_q == RD_XFER) && tx_q[CMD_BITS-1];
  assign busy_o = (state_q == RD_XFER);
  assign done_o = done_q;
  // First received byte sits in the upper half: it is the even-address byte.
  assign word_o = {rx_q[7:0], rx_q[WORD_W-1:8]};

  // R3: the clock only pulses while the device is selected (mode 0 framing)
  p_sck_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> !csn_q);
  // R4: completion is flagged only at the end of a transfer
  p_done_after_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(state_q) == RD_XFER);
endmodule

// File: rtl/eep_pin_arbiter.sv
module eep_pin_arbiter #(
  parameter int unsigned IDLE_TIMEOUT = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl_i,
  input  logic wreq_i,
  input  logic pin_act_i,
  input  logic idle_i,
  output logic req_o,
  output logic gnt_o
);
  localparam int unsigned TW = $clog2(IDLE_TIMEOUT + 1);

  logic          req_q, req_d;
  logic          gnt_q, gnt_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          expire;

  always_comb begin
    expire = gnt_q && !pin_act_i && (cnt_q == TW'(IDLE_TIMEOUT - 1));
    if (wr_ctl_i)    req_d = wreq_i;
    else if (expire) req_d = 1'b0;
    else             req_d = req_q;
    gnt_d = req_d && (gnt_q || idle_i);
    if (!gnt_q || pin_act_i || expire) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gnt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      gnt_q <= gnt_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_o = req_q;
  assign gnt_o = gnt_q;

  // R5: a grant is only ever held under a standing request
  p_gnt_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q |-> req_q);
  // R9: a grant starts only from an idle engine with nothing waiting
  p_gnt_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(idle_i));
  // R10: the inactivity count never runs past its limit
  p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TW'(IDLE_TIMEOUT));
endmodule

// File: rtl/eeprom_port_ctrl.sv
module eeprom_port_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned DEV_KB       = 16,
  parameter bit          PRESENT      = 1'b1,
  parameter int unsigned SCK_HALF     = 2,
  parameter int unsigned IDLE_TIMEOUT = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam logic [SIZE_W-1:0] SIZE_CODE = size_code(DEV_KB);

  logic rst_sn;
  logic wr_ctl, wr_rd, go_wr, launch, pin_act;
  logic req, gnt;
  logic eng_sck, eng_csn, eng_mosi, eng_busy, eng_done;
  logic [WORD_W-1:0] eng_word;

  logic               ctl_sck_q, ctl_sck_d;
  logic               ctl_cs_q, ctl_cs_d;
  logic               ctl_do_q, ctl_do_d;
  logic               pend_q, pend_d;
  logic               done_q, done_d;
  logic [WADDR_W-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic [31:0]        ctl_view, rd_view;
  logic               unused_wdata_hi;

  eep_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign wr_ctl  = host_wr && !host_sel;
  assign wr_rd   = host_wr && host_sel;
  assign go_wr   = wr_rd && host_wdata[RB_GO];
  assign pin_act = wr_ctl &&
                   ({host_wdata[CB_DO], host_wdata[CB_CS], host_wdata[CB_SCK]} !=
                    {ctl_do_q, ctl_cs_q, ctl_sck_q});
  assign launch  = pend_q && !gnt && !eng_busy;
  assign unused_wdata_hi = ^host_wdata[31:16];

  eep_pin_arbiter #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_arb (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_ctl_i (wr_ctl),
    .wreq_i   (host_wdata[CB_REQ]),
    .pin_act_i(pin_act),
    .idle_i   (!eng_busy && !pend_q),
    .req_o    (req),
    .gnt_o    (gnt)
  );

  eep_word_reader #(.SCK_HALF(SCK_HALF)) u_rdr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .start_i(launch),
    .waddr_i(waddr_q),
    .miso_i (spi_miso),
    .sck_o  (eng_sck),
    .cs_n_o (eng_csn),
    .mosi_o (eng_mosi),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .word_o (eng_word)
  );

  // Next-state for host-visible registers
  always_comb begin
    ctl_sck_d = ctl_sck_q;
    ctl_cs_d  = ctl_cs_q;
    ctl_do_d  = ctl_do_q;
    if (wr_ctl) begin
      ctl_sck_d = host_wdata[CB_SCK];
      ctl_cs_d  = host_wdata[CB_CS];
      ctl_do_d  = host_wdata[CB_DO];
    end
    waddr_d = go_wr ? host_wdata[RB_ADDR +: WADDR_W] : waddr_q;
    if (go_wr)       pend_d = 1'b1;
    else if (launch) pend_d = 1'b0;
    else             pend_d = pend_q;
    if (go_wr)         done_d = 1'b0;
    else if (eng_done) done_d = 1'b1;
    else               done_d = done_q;
    word_d = eng_done ? eng_word : word_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_sck_q <= 1'b0;
      ctl_cs_q  <= 1'b1;
      ctl_do_q  <= 1'b0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      waddr_q   <= '0;
      word_q    <= '0;
    end else begin
      ctl_sck_q <= ctl_sck_d;
      ctl_cs_q  <= ctl_cs_d;
      ctl_do_q  <= ctl_do_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
      waddr_q   <= waddr_d;
      word_q    <= word_d;
    end
  end

  // Pin ownership
  assign spi_sck  = gnt ? ctl_sck_q : eng_sck;
  assign spi_cs_n = gnt ? ctl_cs_q  : eng_csn;
  assign spi_mosi = gnt ? ctl_do_q  : eng_mosi;

  // Register read views
  always_comb begin
    ctl_view = '0;
    ctl_view[CB_SCK]  = ctl_sck_q;
    ctl_view[CB_CS]   = ctl_cs_q;
    ctl_view[CB_DO]   = ctl_do_q;
    ctl_view[CB_DI]   = spi_miso;
    ctl_view[CB_REQ]  = req;
    ctl_view[CB_GNT]  = gnt;
    ctl_view[CB_PRES] = PRESENT;
    ctl_view[CB_SIZE +: SIZE_W] = SIZE_CODE;
    rd_view = '0;
    rd_view[RB_GO]   = pend_q || eng_busy;
    rd_view[RB_DONE] = done_q;
    rd_view[RB_ADDR +: WADDR_W] = waddr_q;
    rd_view[RB_DATA +: WORD_W]  = word_q;
  end

  assign host_rdata = host_sel ? rd_view : ctl_view;

  // R9: the engine and a grant never own the pins together
  p_no_shared_pins_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    gnt |-> !eng_busy);
  // R8: a waiting fetch is kept for as long as the grant lasts
  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (gnt && pend_q) |=> pend_q);
  // R11: outside a grant and a fetch the pins rest in their idle levels
  p_pins_idle_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (!gnt && !eng_busy) |-> (spi_cs_n && !spi_sck));
endmodule

// File: tb/eeprom_port_ctrl_test.sv
module eeprom_port_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int KB         = 32;
  localparam int NVEC       = 6;
  localparam logic [13:0] VEC_W [NVEC] = '{14'h0000, 14'h0001, 14'h3FFF,
                                           14'h1234, 14'h2AAA, 14'h0155};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr;
  logic [31:0] host_wdata, host_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic        miso_force;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  eeprom_port_ctrl #(.DEV_KB(KB), .PRESENT(1'b1), .SCK_HALF(2), .IDLE_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  // EEPROM model contents
  function automatic logic [7:0] ebyte(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd3;
    return m ^ a[15:8] ^ 8'h5C;
  endfunction

  // Serial EEPROM model (mode 0)
  logic [6:0]  m_cnt = '0;
  logic [23:0] m_cap = '0;
  logic [7:0]  m_op = '0;
  logic [15:0] m_addr = '0;
  logic [15:0] m_stream = '0;
  logic        m_out = 1'b0;

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (!spi_sck) begin
      m_cnt = '0;
    end else if (!spi_cs_n) begin
      if (m_cnt < 7'd24) begin
        m_cap = {m_cap[22:0], spi_mosi};
        if (m_cnt == 7'd23) begin
          m_op     = m_cap[23:16];
          m_addr   = m_cap[15:0];
          m_stream = {ebyte(m_cap[15:0]), ebyte(m_cap[15:0] + 16'd1)};
        end
      end
      if (m_cnt != 7'h7F) m_cnt = m_cnt + 7'd1;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && m_cnt >= 7'd24 && m_cnt < 7'd40)
      m_out = m_stream[39 - int'(m_cnt)];
  end

  assign spi_miso = spi_cs_n ? miso_force : m_out;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit sck, input bit cs, input bit dout, input bit req);
    logic [31:0] v;
    v = '0;
    v[0] = sck; v[1] = cs; v[2] = dout; v[6] = req;
    return v;
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  task automatic wait_done(output logic [31:0] d);
    d = '0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(1'b1, d);
      if (d[1]) break;
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [13:0] w);
    return {ebyte({1'b0, w, 1'b1}), ebyte({1'b0, w, 1'b0})};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, base;
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_wdata = '0; miso_force = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R2/R11 reset state
    base = 32'h0000_0002 | (32'd1 << 8) | (32'd8 << 11);
    rd(1'b0, d);
    chk(d == base, "R1 R2 reset control value", d, base);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 idle pins after reset",
        {30'd0, spi_cs_n, spi_sck}, 32'h2);

    // Vector walk: fetch, check wire frame and returned word
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b1, {16'h0, VEC_W[i], 2'b01});
      rd(1'b1, d);
      chk(d[1] == 1'b0 && d[0] == 1'b1, "R4 done cleared, busy set on start", d, 32'h1);
      wait_done(d);
      chk(d[31:16] == exp_word(VEC_W[i]), "R4 word byte order", {16'h0, d[31:16]},
          {16'h0, exp_word(VEC_W[i])});
      chk(m_op == 8'h03 && m_addr == {1'b0, VEC_W[i], 1'b0}, "R3 opcode and byte address",
          {8'h0, m_op, m_addr}, {16'h0003, 1'b0, VEC_W[i], 1'b0});
    end

    // R7 pins ignore control bits without grant
    wr(1'b0, ctl(1'b1, 1'b0, 1'b1, 1'b0));
    chk(spi_cs_n && !spi_sck && !spi_mosi, "R7 pins unchanged without grant",
        {29'd0, spi_mosi, spi_cs_n, spi_sck}, 32'h2);

    // R2 size and present ignore writes
    wr(1'b0, 32'hFFFF_FFBF);
    rd(1'b0, d);
    chk(d[8] == 1'b1 && d[14:11] == 4'd8, "R2 size/present read-only", {17'd0, d[14:8]}, 32'h41);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b0));

    // R5 grant visible on next read
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    rd(1'b0, d);
    chk(d[7] == 1'b1 && d[6] == 1'b1, "R5 grant after request", {24'd0, d[7:0]}, 32'hC2);

    // R6 direct pin drive and miso reflection
    wr(1'b0, ctl(1'b1, 1'b0, 1'b1, 1'b1));
    chk(spi_sck && !spi_cs_n && spi_mosi, "R6 pins follow control bits",
        {29'd0, spi_mosi, spi_cs_n, spi_sck}, 32'h5);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    miso_force = 1'b1;
    rd(1'b0, d);
    chk(d[3] == 1'b1, "R6 data-in bit reflects pin high", d, 32'h8);
    miso_force = 1'b0;
    rd(1'b0, d);
    chk(d[3] == 1'b0, "R6 data-in bit reflects pin low", d, 32'h0);

    // R8 fetch waits for grant release
    wr(1'b1, {16'h0, 14'h0ABC, 2'b01});
    repeat (30) @(negedge clk);
    rd(1'b1, d);
    chk(spi_cs_n == 1'b1 && d[1] == 1'b0, "R8 fetch held during grant", {d[31:2], spi_cs_n, d[1]}, 32'h2);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b0));
    wait_done(d);
    chk(d[1] && d[31:16] == exp_word(14'h0ABC), "R8 fetch completes after release",
        {16'h0, d[31:16]}, {16'h0, exp_word(14'h0ABC)});

    // R9 request during a fetch is deferred
    wr(1'b1, {16'h0, 14'h0033, 2'b01});
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    rd(1'b0, d);
    chk(d[7] == 1'b0 && d[6] == 1'b1, "R9 no grant while fetch runs", {24'd0, d[7:0]}, 32'h42);
    wait_done(d);
    chk(d[31:16] == exp_word(14'h0033), "R9 fetch unaffected by request",
        {16'h0, d[31:16]}, {16'h0, exp_word(14'h0033)});
    @(negedge clk);
    rd(1'b0, d);
    chk(d[7] == 1'b1, "R9 grant after fetch ends", {24'd0, d[7:0]}, 32'hC2);

    // R10 inactivity timeout
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b0));
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    repeat (TMO - 1) @(negedge clk);
    rd(1'b0, d);
    chk(d[7] == 1'b1, "R10 grant held before timeout", {24'd0, d[7:0]}, 32'hC2);
    repeat (2) @(negedge clk);
    rd(1'b0, d);
    chk(d[7] == 1'b0 && d[6] == 1'b0, "R10 request and grant cleared", {24'd0, d[7:0]}, 32'h02);
    wr(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    repeat (TMO - 3) @(negedge clk);
    wr(1'b0, ctl(1'b1, 1'b1, 1'b0, 1'b1));
    repeat (TMO - 1) @(negedge clk);
    rd(1'b0, d);
    chk(d[7] == 1'b1, "R10 pin change restarts count", {24'd0, d[7:0]}, 32'hC3);
    repeat (2) @(negedge clk);
    rd(1'b0, d);
    chk(d[7] == 1'b0, "R10 timeout after restart", {24'd0, d[7:0]}, 32'h03);
    chk(spi_cs_n && !spi_sck, "R11 idle pins after grant loss", {30'd0, spi_cs_n, spi_sck}, 32'h2);

    // R3 engine usable again after timeout
    wr(1'b1, {16'h0, 14'h2001, 2'b01});
    wait_done(d);
    chk(m_addr == 16'h4002 && d[31:16] == exp_word(14'h2001), "R3 fetch after timeout",
        {m_addr, d[31:16]}, {16'h4002, exp_word(14'h2001)});

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule